// File: doc/BRIEF.md
# Product-Term Macrocell with Term Steering

This block models a single output cell of a sum-of-products logic block. Five direct product terms arrive with the cell. A configuration word gives each of them a role. A term can feed the sum, or it can act as a clock, a set, a reset or an output enable. A shared pool of extra product terms is also presented, together with a mask that marks which of them belong to this cell. The masked pool terms are ORed into the sum. A programmable inversion follows the sum. The result then goes to a storage element, which can be configured as a D flip-flop or a T flip-flop, or can be bypassed.

The storage element is modelled on one system clock `clk`. The selected cell clock is one of three global clocks, taken in true or complement polarity, or the OR of the clock-role terms. The model watches this selected clock and counts a rising edge as the active event. Set, reset and the global set/reset act without waiting for that event. They take effect on the next `clk` edge. A synchronous active-low `rst_n` stands for power-up and loads the configured preset value. Arbitration of the pool among neighbouring cells is outside this block.

Top module: `pterm_macrocell`

## Requirements
- R1: The sum is the OR of every direct term whose role code is 0 (data) together with every pool term whose mask bit is 1. Direct terms with any other role code, and pool terms whose mask bit is 0, do not affect the sum.
- R2: Config bit 15 inverts the sum when it is 1.
- R3: When the mode field (config bits 17:16) is 2 or 3, `mc_out` follows the inverted sum combinationally, with no clock needed.
- R4: In mode 0 (D), the register loads the inverted sum on a rising edge of the selected clock. With no such edge it holds its value.
- R5: In mode 1 (T), the register toggles on a rising edge of the selected clock when the inverted sum is 1. It holds when the inverted sum is 0.
- R6: The clock select field (config bits 19:18) picks the clock source. Values 0, 1 and 2 pick `gclk[0]`, `gclk[1]` and `gclk[2]`. Value 3 picks the OR of the terms with role code 1. When config bit 20 is 1, the complement of the chosen global clock is used, so a falling edge of that clock becomes the active event.
- R7: A term with role code 3 (reset) that is high clears the register on the next `clk` edge, with no active clock event needed. Reset wins over set.
- R8: A term with role code 2 (set) that is high, while no reset term is high, sets the register on the next `clk` edge.
- R9: `gsr` loads the preset value (config bit 21) on the next `clk` edge. It overrides set, reset and clock events.
- R10: While `rst_n` is low, the register loads the preset value (config bit 21).
- R11: The output-enable field (config bits 23:22) sets `mc_oe`. Value 0 holds it at 1. Value 1 makes it follow `goe`. Value 2 makes it the OR of the terms with role code 4. Value 3 holds it at 0.

Role codes sit in config bits [3i+2:3i] for direct term i. Codes 5 to 7 give a term no use.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; samples every event |
| rst_n | input | 1 | Synchronous active-low power-up reset |
| pt_dir | input | 5 | Direct product terms |
| pool_pt | input | POOL_W | Shared pool product terms |
| pool_mask | input | POOL_W | Pool terms allocated to this cell |
| gclk | input | 3 | Global clocks |
| gsr | input | 1 | Global set/reset to the preset value |
| goe | input | 1 | Global output enable |
| cfg | input | 24 | Configuration word (layout in requirements) |
| mc_out | output | 1 | Cell output (register or bypassed sum) |
| mc_oe | output | 1 | Cell output enable |

## Verification
The hardest case to reach is when control terms and clock events coincide. This covers a reset term raised together with a set term, and a global set/reset raised together with a live clock edge, each tried from both register values. The bench first forces the register to a known start value through the global set/reset. It then applies every set/reset combination while the selected clock stays idle. For clock selection, the bench sets the idle levels of the global clocks to match the chosen polarity, so a configuration change cannot pass for an edge. It then pulses each source in turn.

// File: rtl/pterm_mc_pkg.sv
// Shared constants, encodings and the configuration decoder for the macrocell.
// Assumes the raw configuration layout described in the brief.
package pterm_mc_pkg;
    localparam int N_DIR     = 5;
    localparam int N_GCLK    = 3;
    localparam int ROLE_W    = 3;
    localparam int CSEL_W    = $clog2(N_GCLK + 1);
    localparam int ROLE_BITS = N_DIR * ROLE_W;
    localparam int CFG_INV   = ROLE_BITS;
    localparam int CFG_MODE  = CFG_INV + 1;
    localparam int CFG_CSEL  = CFG_MODE + 2;
    localparam int CFG_CINV  = CFG_CSEL + CSEL_W;
    localparam int CFG_INIT  = CFG_CINV + 1;
    localparam int CFG_OE    = CFG_INIT + 1;
    localparam int CFG_W     = CFG_OE + 2;

    typedef enum logic [ROLE_W-1:0] {
        ROLE_DATA = 3'd0,
        ROLE_CLK  = 3'd1,
        ROLE_SET  = 3'd2,
        ROLE_RST  = 3'd3,
        ROLE_OE   = 3'd4,
        ROLE_NONE = 3'd5
    } role_e;

    typedef enum logic [1:0] {
        REG_D       = 2'd0,
        REG_T       = 2'd1,
        REG_BYP     = 2'd2,
        REG_BYP_ALT = 2'd3
    } reg_mode_e;

    typedef enum logic [1:0] {
        OE_ON     = 2'd0,
        OE_GLOBAL = 2'd1,
        OE_TERM   = 2'd2,
        OE_OFF    = 2'd3
    } oe_sel_e;

    typedef struct packed {
        logic [N_DIR-1:0][ROLE_W-1:0] role;
        logic                         invert;
        reg_mode_e                    mode;
        logic [CSEL_W-1:0]            clk_sel;
        logic                         clk_inv;
        logic                         init_val;
        oe_sel_e                      oe_sel;
    } mc_cfg_t;

    // Split the flat configuration word into named fields.
    function automatic mc_cfg_t unpack_cfg(input logic [CFG_W-1:0] raw);
        mc_cfg_t c;
        for (int i = 0; i < N_DIR; i++) begin
            c.role[i] = raw[i*ROLE_W +: ROLE_W];
        end
        c.invert   = raw[CFG_INV];
        c.mode     = reg_mode_e'(raw[CFG_MODE +: 2]);
        c.clk_sel  = raw[CFG_CSEL +: CSEL_W];
        c.clk_inv  = raw[CFG_CINV];
        c.init_val = raw[CFG_INIT];
        c.oe_sel   = oe_sel_e'(raw[CFG_OE +: 2]);
        return c;
    endfunction
endpackage

// File: rtl/mc_term_router.sv
// Steers each direct product term to the data path or to one control duty.
// Assumes several terms may share a control role; they are ORed together.
module mc_term_router
    import pterm_mc_pkg::*;
(
    input  logic [N_DIR-1:0]              pt_dir,
    input  logic [N_DIR-1:0][ROLE_W-1:0]  role,
    output logic [N_DIR-1:0]              data_mask,
    output logic                          ctl_clk,
    output logic                          ctl_set,
    output logic                          ctl_rst,
    output logic                          ctl_oe
);
    logic [N_DIR-1:0] is_clk;
    logic [N_DIR-1:0] is_set;
    logic [N_DIR-1:0] is_rst;
    logic [N_DIR-1:0] is_oe;

    generate
        for (genvar i = 0; i < N_DIR; i++) begin : g_term
            assign data_mask[i] = (role[i] == ROLE_DATA);
            assign is_clk[i]    = pt_dir[i] & (role[i] == ROLE_CLK);
            assign is_set[i]    = pt_dir[i] & (role[i] == ROLE_SET);
            assign is_rst[i]    = pt_dir[i] & (role[i] == ROLE_RST);
            assign is_oe[i]     = pt_dir[i] & (role[i] == ROLE_OE);
        end
    endgenerate

    assign ctl_clk = |is_clk;
    assign ctl_set = |is_set;
    assign ctl_rst = |is_rst;
    assign ctl_oe  = |is_oe;
endmodule

// File: rtl/mc_sum_path.sv
// Forms the sum of data-role direct terms and allocated pool terms, then
// applies the programmable inversion. Purely combinational.
module mc_sum_path
    import pterm_mc_pkg::*;
#(
    parameter int POOL_W = 90
) (
    input  logic [N_DIR-1:0]  pt_dir,
    input  logic [N_DIR-1:0]  data_mask,
    input  logic [POOL_W-1:0] pool_pt,
    input  logic [POOL_W-1:0] pool_mask,
    input  logic              invert,
    output logic              sum_xor
);
    logic dir_sum;
    logic pool_sum;

    assign dir_sum  = |(pt_dir & data_mask);
    assign pool_sum = |(pool_pt & pool_mask);
    assign sum_xor  = (dir_sum | pool_sum) ^ invert;
endmodule

// File: rtl/mc_clk_pick.sv
// Chooses the cell clock source and reports its rising edges as a one-cycle
// event in the system clock domain. Assumes sources change slower than clk.
module mc_clk_pick
    import pterm_mc_pkg::*;
(
    input  logic              clk,
    input  logic [N_GCLK-1:0] gclk,
    input  logic              pt_clk,
    input  logic [CSEL_W-1:0] clk_sel,
    input  logic              clk_inv,
    output logic              clk_edge
);
    localparam int N_SRC = 2 ** CSEL_W;

    logic [N_SRC-1:0] src_set;
    logic             src_lvl;
    logic             src_prev;

    generate
        for (genvar k = 0; k < N_SRC; k++) begin : g_src
            if (k < N_GCLK) begin : g_glob
                assign src_set[k] = gclk[k] ^ clk_inv;
            end else begin : g_term
                assign src_set[k] = pt_clk;
            end
        end
    endgenerate

    assign src_lvl = src_set[clk_sel];

    // Remember the selected level to find its next rising edge.
    always_ff @(posedge clk) begin
        src_prev <= src_lvl;
    end

    assign clk_edge = src_lvl & ~src_prev;
endmodule

// File: rtl/mc_state_reg.sv
// The macrocell storage bit: D, T or hold-in-bypass, with priority
// global set/reset > reset term > set term > clock event.
// Assumes rst_n is synchronous and active low.
module mc_state_reg
    import pterm_mc_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  reg_mode_e mode,
    input  logic      d,
    input  logic      clk_edge,
    input  logic      gsr,
    input  logic      ctl_set,
    input  logic      ctl_rst,
    input  logic      init_val,
    output logic      q
);
    logic q_next;

    // Resolve the next state from the control priority and the mode.
    always_comb begin
        q_next = q;
        if (clk_edge) begin
            case (mode)
                REG_D:   q_next = d;
                REG_T:   q_next = q ^ d;
                default: q_next = q;
            endcase
        end
        if (ctl_set) q_next = 1'b1;
        if (ctl_rst) q_next = 1'b0;
        if (gsr)     q_next = init_val;
    end

    // Load the preset on reset, otherwise take the resolved next state.
    always_ff @(posedge clk) begin
        if (!rst_n) q <= init_val;
        else        q <= q_next;
    end

    AST_GSR_PRESET: assert property (@(posedge clk) disable iff (!rst_n)
        gsr |=> q == $past(init_val)); // R9
    AST_RST_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        !gsr && ctl_rst |=> !q); // R7
    AST_SET_TERM: assert property (@(posedge clk) disable iff (!rst_n)
        !gsr && !ctl_rst && ctl_set |=> q); // R8
    AST_D_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
        mode == REG_D && clk_edge && !gsr && !ctl_rst && !ctl_set |=> q == $past(d)); // R4
    AST_T_TOGGLE: assert property (@(posedge clk) disable iff (!rst_n)
        mode == REG_T && clk_edge && d && !gsr && !ctl_rst && !ctl_set |=> q != $past(q)); // R5
    AST_HOLD_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !clk_edge && !gsr && !ctl_rst && !ctl_set |=> $stable(q)); // R4
endmodule

// File: rtl/pterm_macrocell.sv
// Top of one product-term macrocell: decodes configuration, routes direct
// terms, sums them with the allocated pool, stores or bypasses the result and
// selects the output enable. Assumes one system clock samples every input.
module pterm_macrocell
    import pterm_mc_pkg::*;
#(
    parameter int POOL_W = 90
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [N_DIR-1:0]  pt_dir,
    input  logic [POOL_W-1:0] pool_pt,
    input  logic [POOL_W-1:0] pool_mask,
    input  logic [N_GCLK-1:0] gclk,
    input  logic              gsr,
    input  logic              goe,
    input  logic [CFG_W-1:0]  cfg,
    output logic              mc_out,
    output logic              mc_oe
);
    mc_cfg_t          c;
    logic [N_DIR-1:0] data_mask;
    logic             ctl_clk;
    logic             ctl_set;
    logic             ctl_rst;
    logic             ctl_oe;
    logic             sum_xor;
    logic             clk_edge;
    logic             q;
    logic             bypass;

    assign c      = unpack_cfg(cfg);
    assign bypass = c.mode[1];

    mc_term_router u_router (
        .pt_dir    (pt_dir),
        .role      (c.role),
        .data_mask (data_mask),
        .ctl_clk   (ctl_clk),
        .ctl_set   (ctl_set),
        .ctl_rst   (ctl_rst),
        .ctl_oe    (ctl_oe)
    );

    mc_sum_path #(.POOL_W(POOL_W)) u_sum (
        .pt_dir    (pt_dir),
        .data_mask (data_mask),
        .pool_pt   (pool_pt),
        .pool_mask (pool_mask),
        .invert    (c.invert),
        .sum_xor   (sum_xor)
    );

    mc_clk_pick u_clk (
        .clk      (clk),
        .gclk     (gclk),
        .pt_clk   (ctl_clk),
        .clk_sel  (c.clk_sel),
        .clk_inv  (c.clk_inv),
        .clk_edge (clk_edge)
    );

    mc_state_reg u_reg (
        .clk      (clk),
        .rst_n    (rst_n),
        .mode     (c.mode),
        .d        (sum_xor),
        .clk_edge (clk_edge),
        .gsr      (gsr),
        .ctl_set  (ctl_set),
        .ctl_rst  (ctl_rst),
        .init_val (c.init_val),
        .q        (q)
    );

    // Pick the register or the live sum for the cell output.
    always_comb begin
        mc_out = bypass ? sum_xor : q;
    end

    // Select the output enable source.
    always_comb begin
        case (c.oe_sel)
            OE_ON:     mc_oe = 1'b1;
            OE_GLOBAL: mc_oe = goe;
            OE_TERM:   mc_oe = ctl_oe;
            default:   mc_oe = 1'b0;
        endcase
    end

    AST_BYPASS_SEES_POOL: assert property (@(posedge clk) disable iff (!rst_n)
        bypass && |(pool_pt & pool_mask) |-> mc_out == !c.invert); // R1
endmodule

// File: tb/pterm_macrocell_tb.sv
`timescale 1ns/1ps
module pterm_macrocell_tb;
    localparam int POOL = 90;
    localparam logic [2:0] RD = 3'd0, RC = 3'd1, RS = 3'd2, RR = 3'd3, RO = 3'd4, RN = 3'd5;

    logic            clk = 1'b0;
    logic            rst_n;
    logic [4:0]      pt_dir;
    logic [POOL-1:0] pool_pt;
    logic [POOL-1:0] pool_mask;
    logic [2:0]      gclk;
    logic            gsr;
    logic            goe;
    logic [23:0]     cfg;
    logic            mc_out;
    logic            mc_oe;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    pterm_macrocell #(.POOL_W(POOL)) u_dut (
        .clk(clk), .rst_n(rst_n), .pt_dir(pt_dir), .pool_pt(pool_pt),
        .pool_mask(pool_mask), .gclk(gclk), .gsr(gsr), .goe(goe),
        .cfg(cfg), .mc_out(mc_out), .mc_oe(mc_oe)
    );

    always #2 clk = ~clk;

    function automatic logic [23:0] mk_cfg(
        input logic [2:0] r0, input logic [2:0] r1, input logic [2:0] r2,
        input logic [2:0] r3, input logic [2:0] r4, input logic inv,
        input logic [1:0] mode, input logic [1:0] csel, input logic cinv,
        input logic init, input logic [1:0] oe);
        return {oe, init, cinv, csel, mode, inv, r4, r3, r2, r1, r0};
    endfunction

    task automatic chk(input logic got, input logic exp, input string req);
        n_chk++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: got %0b expected %0b", req, got, exp);
        end
    endtask

    task automatic step();
        @(negedge clk);
    endtask

    task automatic preset(input logic [23:0] c);
        cfg = c;
        gsr = 1'b1;
        step();
        gsr = 1'b0;
        step();
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog (all requirements): got hung expected done");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        logic exp;
        logic [7:0] tseq;
        rst_n = 1'b0; pt_dir = '0; pool_pt = '0; pool_mask = '0;
        gclk = '0; gsr = 1'b0; goe = 1'b0;

        // R10: power-up preset, both values
        cfg = mk_cfg(RD, RD, RD, RD, RD, 1'b0, 2'd0, 2'd0, 1'b0, 1'b1, 2'd0);
        step(); step();
        chk(mc_out, 1'b1, "R10 reset loads preset 1");
        chk(mc_oe, 1'b1, "R11 oe field 0 holds enable");
        cfg[21] = 1'b0;
        step();
        chk(mc_out, 1'b0, "R10 reset loads preset 0");
        rst_n = 1'b1;
        step();

        // R1 R2 R3: role masks x term patterns x inversion in bypass
        for (int m = 0; m < 32; m++) begin
            logic [2:0] r [5];
            for (int i = 0; i < 5; i++) r[i] = m[i] ? RD : 3'(1 + i);
            for (int p = 0; p < 32; p++) begin
                for (int v = 0; v < 2; v++) begin
                    cfg = mk_cfg(r[0], r[1], r[2], r[3], r[4], v[0], 2'd2, 2'd0, 1'b0, 1'b0, 2'd0);
                    pt_dir = p[4:0];
                    #1;
                    exp = (|(p[4:0] & m[4:0])) ^ v[0];
                    chk(mc_out, exp, "R1 R2 R3 bypass sum of data-role terms");
                end
            end
        end
        step();

        // R1: pool allocation mask
        pt_dir = '0;
        for (int k = 0; k < POOL; k++) begin
            cfg = mk_cfg(RD, RD, RD, RD, RD, k[0], 2'd3, 2'd0, 1'b0, 1'b0, 2'd0);
            pool_pt = '0;
            pool_pt[k] = 1'b1;
            pool_mask = '1;
            if (k % 3 == 1) pool_mask[k] = 1'b0;
            #1;
            exp = (k % 3 != 1) ^ k[0];
            chk(mc_out, exp, "R1 pool term masked sum");
        end
        pool_pt = '1; pool_mask = '0;
        cfg[15] = 1'b0;
        #1;
        chk(mc_out, 1'b0, "R1 unallocated pool ignored");
        pool_pt = '0;
        step();

        // R4: D capture and hold
        preset(mk_cfg(RD, RD, RD, RD, RD, 1'b0, 2'd0, 2'd0, 1'b0, 1'b0, 2'd0));
        for (int i = 0; i < 4; i++) begin
            logic [3:0] vals;
            vals = 4'b0110;
            pt_dir = {4'b0, vals[i]};
            gclk[0] = 1'b1;
            step();
            chk(mc_out, vals[i], "R4 D capture on edge");
            gclk[0] = 1'b0;
            pt_dir = {4'b0, ~vals[i]};
            step();
            chk(mc_out, vals[i], "R4 D hold without edge");
        end

        // R5: T toggling
        preset(mk_cfg(RD, RD, RD, RD, RD, 1'b0, 2'd1, 2'd0, 1'b0, 1'b0, 2'd0));
        tseq = 8'b1011_0110;
        exp = 1'b0;
        for (int i = 0; i < 8; i++) begin
            pt_dir = {4'b0, tseq[i]};
            gclk[0] = 1'b1;
            step();
            exp = exp ^ tseq[i];
            chk(mc_out, exp, "R5 T toggle on edge when sum is 1");
            gclk[0] = 1'b0;
            step();
        end

        // R6: clock source and polarity sweep
        for (int s = 0; s < 4; s++) begin
            for (int ci = 0; ci < 2; ci++) begin
                logic [2:0] idle;
                idle = ci[0] ? 3'b111 : 3'b000;
                gclk = idle;
                pt_dir = 5'b00001;
                preset(mk_cfg(RD, RN, RN, RN, RC, 1'b0, 2'd0, s[1:0], ci[0], 1'b0, 2'd0));
                for (int j = 0; j < 4; j++) begin
                    if (j < 3) gclk[j] = ~idle[j];
                    else       pt_dir[4] = 1'b1;
                    step();
                    chk(mc_out, j == s, "R6 only the selected clock source loads");
                    gclk = idle;
                    pt_dir[4] = 1'b0;
                    step();
                    gsr = 1'b1; step(); gsr = 1'b0; step();
                end
            end
        end

        // R7 R8: set and reset terms without clock events, from both states
        gclk = '0;
        for (int st = 0; st < 2; st++) begin
            for (int c = 0; c < 4; c++) begin
                pt_dir = '0;
                preset(mk_cfg(RD, RS, RR, RN, RN, 1'b0, 2'd0, 2'd0, 1'b0, st[0], 2'd0));
                pt_dir = {2'b0, c[1], c[0], 1'b1};
                step();
                exp = c[1] ? 1'b0 : (c[0] ? 1'b1 : st[0]);
                if (c[1]) chk(mc_out, exp, "R7 reset term clears, wins over set");
                else      chk(mc_out, exp, "R8 set term sets, else holds");
                pt_dir = '0;
                step();
            end
        end

        // R9: global set/reset overrides terms and clock edges
        cfg = mk_cfg(RD, RS, RR, RN, RN, 1'b0, 2'd0, 2'd0, 1'b0, 1'b1, 2'd0);
        pt_dir = 5'b00100;
        gsr = 1'b1;
        step();
        chk(mc_out, 1'b1, "R9 gsr preset 1 over reset term");
        cfg[21] = 1'b0;
        pt_dir = 5'b00011;
        gclk[0] = 1'b1;
        step();
        chk(mc_out, 1'b0, "R9 gsr preset 0 over set term and edge");
        gsr = 1'b0; gclk = '0; pt_dir = '0;
        step();

        // R11: output enable selection
        for (int o = 0; o < 4; o++) begin
            for (int g = 0; g < 2; g++) begin
                for (int t = 0; t < 2; t++) begin
                    cfg = mk_cfg(RD, RD, RD, RO, RD, 1'b0, 2'd2, 2'd0, 1'b0, 1'b0, o[1:0]);
                    goe = g[0];
                    pt_dir = {1'b0, t[0], 3'b0};
                    #1;
                    case (o)
                        0: exp = 1'b1;
                        1: exp = g[0];
                        2: exp = t[0];
                        default: exp = 1'b0;
                    endcase
                    chk(mc_oe, exp, "R11 output enable source");
                end
            end
        end
        step();

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule